// File: doc/BRIEF.md
# Servo Command Sentinel Resolver

This block stands between the register writes that carry position-mode commands and a position servo loop. It handles three command fields: target position, target velocity and torque ceiling. Software writes the raw words into staging registers by address. When a commit strobe arrives, the block resolves all three fields in one step and registers the results for the loop. Each word is read either as an IEEE-754 single-precision value or as a two's-complement integer, as the format flag present at commit selects.

Each field has a reserved "no value" code. For floating-point words, any NaN is that code. For integer words, it is the most negative value. The block never passes the code downstream; it puts in a defined replacement. An absent velocity becomes zero. An absent torque ceiling becomes the limit derived from the configured phase current. An absent position becomes one of two values. If the loop is already in position mode, it is the last resolved target, so repeated empty position commands keep holding still. Otherwise it is the measured position. A flag beside each output shows that a replacement was used.

Top module: `cmd_sentinel_resolver`

## Requirements
- R1: While and after reset (synchronous, active high), the three resolved outputs read zero, the three substitution flags are low and `res_valid` is low.
- R2: `res_valid` is high in exactly the cycle after a cycle with `cmd_valid` high. The resolved outputs and flags change only on the clock edge that samples `cmd_valid` high, and they hold between commits.
- R3: With `fmt_int` low, a word is the reserved code exactly when bits 30:23 are all ones and bits 22:0 are not all zero. The infinities 32'h7F800000 and 32'hFF800000 pass through unchanged, with the flag low.
- R4: With `fmt_int` high, only 32'h80000000 is the reserved code. Every other integer, including 32'h80000001 and 32'h7FFFFFFF, passes through unchanged.
- R5: A reserved position code that is committed while `in_pos_mode` is low resolves to `meas_pos` as sampled at the commit, and `pos_sub` goes high.
- R6: A reserved position code that is committed while `in_pos_mode` is high resolves to the previously resolved position, and `pos_sub` goes high. Any number of such commits in a row keep the same value.
- R7: A reserved velocity code resolves to the all-zero word, which is 0.0 in both formats, and `vel_sub` goes high.
- R8: A reserved torque code resolves to `trq_limit` as sampled at the commit, and `trq_sub` goes high.
- R9: A word that is not the reserved code passes to its output bit for bit, and its flag is low.
- R10: A write with `wr_en` high loads `wr_data` into the position, velocity or torque staging register when `wr_addr` is 12'h020, 12'h021 or 12'h025 respectively. A write to any other address changes nothing. If a field is written more than once before a commit, the last write is used. Staging registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | 32 | Register write data |
| cmd_valid | input | 1 | Commit strobe: resolve the staged fields |
| fmt_int | input | 1 | 1: integer encoding, 0: single-precision float |
| in_pos_mode | input | 1 | Loop is already in position mode |
| meas_pos | input | 32 | Sampled measured position |
| trq_limit | input | 32 | Torque limit derived from the phase-current limit |
| res_valid | output | 1 | One-cycle pulse: new resolved values |
| pos_res | output | 32 | Resolved target position |
| vel_res | output | 32 | Resolved target velocity |
| trq_res | output | 32 | Resolved torque ceiling |
| pos_sub | output | 1 | Position replacement used |
| vel_sub | output | 1 | Velocity replacement used |
| trq_sub | output | 1 | Torque replacement used |

## Verification
The assertions check four things on every cycle. They check the one-cycle timing of `res_valid`, and that the outputs stay stable between commits. They check that a replaced velocity is zero. They check the replacement rules that depend on the previous cycle: position hold in position mode, measured position outside it, and the torque limit. Only the bench scenarios can show the rest. That covers the exact bit boundary between NaN and infinity, and the uniqueness of the integer reserved code. It also covers address decoding, where a stray write has no effect and the last write wins, and pass-through of random ordinary words. The bench checks those against its own model of the staging registers and the held target.

// File: rtl/cmdres_pkg.sv
package cmdres_pkg;
  localparam int CMD_W      = 32;
  localparam int ADDR_W     = 12;
  localparam int EXP_W      = 8;
  localparam int MAN_W      = 23;
  localparam int NUM_FIELDS = 3;

  typedef enum logic [1:0] {
    FLD_POS = 2'd0,
    FLD_VEL = 2'd1,
    FLD_TRQ = 2'd2
  } field_e;

  typedef struct packed {
    logic [CMD_W-1:0] value;
    logic             sub;
  } resolved_t;
endpackage

// File: rtl/cmdres_sentinel_det.sv
module cmdres_sentinel_det #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] word,
  input  logic         fmt_int,
  output logic         hit
);
  localparam logic [W-1:0] INT_MIN = {1'b1, {(W-1){1'b0}}};

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             float_nan;
  logic             int_min;

  assign exp_f = word[W-2 -: EXP_W];
  assign man_f = word[MAN_W-1:0];

  always_comb begin
    float_nan = (&exp_f) && (|man_f);
    int_min   = (word == INT_MIN);
    hit       = fmt_int ? int_min : float_nan;
  end
endmodule

// File: rtl/cmdres_stage.sv
module cmdres_stage #(
  parameter int                ADDR_W = 12,
  parameter int                DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADDR   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);
  logic sel;
  assign sel = wr_en && (wr_addr == ADDR);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (sel) q <= wr_data;
  end
endmodule

// File: rtl/cmd_sentinel_resolver.sv
module cmd_sentinel_resolver
  import cmdres_pkg::*;
#(
  parameter int                ADDR_BITS = ADDR_W,
  parameter logic [ADDR_BITS-1:0] POS_ADDR = 12'h020,
  parameter logic [ADDR_BITS-1:0] VEL_ADDR = 12'h021,
  parameter logic [ADDR_BITS-1:0] TRQ_ADDR = 12'h025
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [CMD_W-1:0]     wr_data,
  input  logic                 cmd_valid,
  input  logic                 fmt_int,
  input  logic                 in_pos_mode,
  input  logic [CMD_W-1:0]     meas_pos,
  input  logic [CMD_W-1:0]     trq_limit,
  output logic                 res_valid,
  output logic [CMD_W-1:0]     pos_res,
  output logic [CMD_W-1:0]     vel_res,
  output logic [CMD_W-1:0]     trq_res,
  output logic                 pos_sub,
  output logic                 vel_sub,
  output logic                 trq_sub
);
  localparam logic [NUM_FIELDS-1:0][ADDR_BITS-1:0] FIELD_ADDR =
    {TRQ_ADDR, VEL_ADDR, POS_ADDR};

  logic [NUM_FIELDS-1:0][CMD_W-1:0] staged;
  logic [NUM_FIELDS-1:0]            hit;
  resolved_t [NUM_FIELDS-1:0]       nxt;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    cmdres_stage #(
      .ADDR_W (ADDR_BITS),
      .DATA_W (CMD_W),
      .ADDR   (FIELD_ADDR[f])
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .q       (staged[f])
    );

    cmdres_sentinel_det #(
      .EXP_W (EXP_W),
      .MAN_W (MAN_W)
    ) u_det (
      .word    (staged[f]),
      .fmt_int (fmt_int),
      .hit     (hit[f])
    );

    if (f == FLD_POS) begin : g_pos
      always_comb begin
        nxt[f].sub   = hit[f];
        if (!hit[f])          nxt[f].value = staged[f];
        else if (in_pos_mode) nxt[f].value = pos_res;
        else                  nxt[f].value = meas_pos;
      end
    end else if (f == FLD_VEL) begin : g_vel
      always_comb begin
        nxt[f].sub   = hit[f];
        nxt[f].value = hit[f] ? '0 : staged[f];
      end
    end else begin : g_trq
      always_comb begin
        nxt[f].sub   = hit[f];
        nxt[f].value = hit[f] ? trq_limit : staged[f];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      pos_res   <= '0;
      vel_res   <= '0;
      trq_res   <= '0;
      pos_sub   <= 1'b0;
      vel_sub   <= 1'b0;
      trq_sub   <= 1'b0;
    end else begin
      res_valid <= cmd_valid;
      if (cmd_valid) begin
        pos_res <= nxt[FLD_POS].value;
        vel_res <= nxt[FLD_VEL].value;
        trq_res <= nxt[FLD_TRQ].value;
        pos_sub <= nxt[FLD_POS].sub;
        vel_sub <= nxt[FLD_VEL].sub;
        trq_sub <= nxt[FLD_TRQ].sub;
      end
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> res_valid);
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !res_valid);
  p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(pos_res) && $stable(vel_res) && $stable(trq_res)
                    && $stable(pos_sub) && $stable(vel_sub) && $stable(trq_sub)));
  p_pos_meas_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && hit[FLD_POS] && !in_pos_mode) |=> (pos_sub && pos_res == $past(meas_pos)));
  p_pos_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && hit[FLD_POS] && in_pos_mode) |=> (pos_sub && $stable(pos_res)));
  p_vel_zero_r7: assert property (@(posedge clk) disable iff (rst)
    vel_sub |-> (vel_res == '0));
  p_trq_limit_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && hit[FLD_TRQ]) |=> (trq_sub && trq_res == $past(trq_limit)));
endmodule

// File: tb/tb_cmd_sentinel_resolver.sv
module tb_cmd_sentinel_resolver;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic        cmd_valid;
  logic        fmt_int;
  logic        in_pos_mode;
  logic [31:0] meas_pos;
  logic [31:0] trq_limit;
  logic        res_valid;
  logic [31:0] pos_res, vel_res, trq_res;
  logic        pos_sub, vel_sub, trq_sub;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_pos, m_vel, m_trq, m_held;

  always #4 clk = ~clk;

  cmd_sentinel_resolver dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .fmt_int(fmt_int), .in_pos_mode(in_pos_mode),
    .meas_pos(meas_pos), .trq_limit(trq_limit), .res_valid(res_valid),
    .pos_res(pos_res), .vel_res(vel_res), .trq_res(trq_res),
    .pos_sub(pos_sub), .vel_sub(vel_sub), .trq_sub(trq_sub)
  );

  function automatic bit is_sent(input logic [31:0] w, input bit fi);
    if (fi) return w == 32'h8000_0000;
    return (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 12'h020) m_pos = d;
    if (a == 12'h021) m_vel = d;
    if (a == 12'h025) m_trq = d;
  endtask

  task automatic commit(input bit fi, input bit pm, input logic [31:0] mp, input logic [31:0] tl);
    logic [31:0] ep, ev, et;
    bit sp, sv, st;
    sp = is_sent(m_pos, fi); sv = is_sent(m_vel, fi); st = is_sent(m_trq, fi);
    ep = sp ? (pm ? m_held : mp) : m_pos;
    ev = sv ? 32'h0 : m_vel;
    et = st ? tl : m_trq;
    @(negedge clk);
    cmd_valid = 1'b1; fmt_int = fi; in_pos_mode = pm; meas_pos = mp; trq_limit = tl;
    @(negedge clk);
    cmd_valid = 1'b0;
    meas_pos = ~mp; trq_limit = ~tl;
    chk("R2 res_valid pulse", {31'd0, res_valid}, 32'd1);
    chk(sp ? (pm ? "R6 pos held" : "R5 pos meas") : "R9 pos pass", pos_res, ep);
    chk(sv ? "R7 vel zero" : "R9 vel pass", vel_res, ev);
    chk(st ? "R8 trq limit" : "R9 trq pass", trq_res, et);
    chk(fi ? "R4 flags" : "R3 flags", {29'd0, pos_sub, vel_sub, trq_sub}, {29'd0, sp, sv, st});
    m_held = ep;
    @(negedge clk);
    chk("R2 res_valid low", {31'd0, res_valid}, 32'd0);
    chk("R2 pos stable", pos_res, ep);
  endtask

  function automatic logic [31:0] rnd_word(input bit fi);
    int k;
    k = $urandom_range(0, 3);
    if (k == 0) return fi ? 32'h8000_0000 : {$urandom_range(0, 1) == 1, 8'hFF, 23'd1 + 23'($urandom_range(0, 32'h7FFFFE))};
    return $urandom();
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; cmd_valid = 0;
    fmt_int = 0; in_pos_mode = 0; meas_pos = 0; trq_limit = 0;
    m_pos = 0; m_vel = 0; m_trq = 0; m_held = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 pos_res", pos_res, 32'd0);
    chk("R1 vel_res", vel_res, 32'd0);
    chk("R1 trq_res", trq_res, 32'd0);
    chk("R1 flags", {29'd0, pos_sub, vel_sub, trq_sub}, 32'd0);

    // R3 infinities pass, NaN caught
    wr(12'h020, 32'h7F80_0000); wr(12'h021, 32'hFF80_0000); wr(12'h025, 32'h7F80_0001);
    commit(0, 0, 32'h3F80_0000, 32'h4120_0000);
    // R5 pos NaN out of position mode
    wr(12'h020, 32'hFFC0_0000); wr(12'h021, 32'h7FFF_FFFF); wr(12'h025, 32'h4000_0000);
    commit(0, 0, 32'h4049_0FDB, 32'h4120_0000);
    // R6 repeated NaN in position mode keeps target
    commit(0, 1, 32'h1111_1111, 32'h4120_0000);
    commit(0, 1, 32'h2222_2222, 32'h4120_0000);
    // R4 integer sentinel and its neighbours
    wr(12'h020, 32'h8000_0001); wr(12'h021, 32'h8000_0000); wr(12'h025, 32'h7FFF_FFFF);
    commit(1, 0, 32'h0000_0100, 32'h0000_0200);
    wr(12'h025, 32'h8000_0000); wr(12'h020, 32'h7FC0_0000);
    commit(1, 1, 32'h0000_0300, 32'h0000_0400);
    // R10 stray addresses ignored, last write wins
    wr(12'h021, 32'h0000_0055);
    wr(12'h022, 32'h8000_0000); wr(12'h024, 32'h8000_0000); wr(12'h026, 32'h8000_0000);
    wr(12'h025, 32'h0000_0011); wr(12'h025, 32'h0000_0077);
    commit(1, 0, 32'h0, 32'h0);
    chk("R10 stray write ignored", vel_res, 32'h0000_0055);
    chk("R10 last write wins", trq_res, 32'h0000_0077);

    // random mix
    for (int i = 0; i < 300; i++) begin
      bit fi;
      fi = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 3) != 0) wr(12'h020, rnd_word(fi));
      if ($urandom_range(0, 3) != 0) wr(12'h021, rnd_word(fi));
      if ($urandom_range(0, 3) != 0) wr(12'h025, rnd_word(fi));
      if ($urandom_range(0, 4) == 0) wr(12'h000 + 12'($urandom_range(0, 4095)) | 12'h100, rnd_word(fi));
      commit(fi, ($urandom_range(0, 1) == 1), $urandom(), $urandom());
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule